// File: doc/BRIEF.md
# Min-Sum Check-Node Compressor

This block is a single check node for a fully parallel belief-propagation decoder of a sparse quantum parity-check code. Each of its `DEG` incoming edges carries a variable-to-check message in sign-magnitude form. The node combines those messages with the measured syndrome bit of its check. It then emits a compact summary from which every neighbouring variable node can rebuild its own check-to-variable message.

The summary has four fields: a parity sign, the index of the edge with the smallest magnitude, that smallest magnitude, and the next smallest magnitude. Per-edge exclusive minima are not formed here. A variable node picks `min2` when it owns the selected edge and `min1` when it does not. The datapath is combinational and settles within one cycle, so that check and variable updates together fit a two-cycle iteration. A generate parameter adds an output register that loads on a cycle-enable strobe.

The message path runs at a fixed rate in lockstep with the decoder's iteration counter, so it has no valid/ready handshake and no back-pressure. Each strobe consumes the current inputs unconditionally, and the downstream variable nodes always sample the held tuple. Message encoding: bit `MW` of each `MW+1`-bit lane is the sign, and bits `MW-1:0` are the unsigned magnitude. Lane `i` occupies `msg_in[i*(MW+1) +: MW+1]`.

Top module: `cn_compress`

## Requirements
- R1: `parity_q` equals the XOR of all `DEG` sign bits (bit `MW` of each lane) and `syndrome`.
- R2: `min1_q` equals the smallest magnitude among the `DEG` lanes.
- R3: `sel_q` is the index of the lane holding `min1_q`; when several lanes share that magnitude, the lowest index is chosen.
- R4: `min2_q` equals the smallest magnitude among all lanes other than the selected one, so it equals `min1_q` when the minimum is tied; `min1_q <= min2_q` always holds.
- R5: `sel_q` is always less than `DEG`, including when every magnitude is at full scale (all ones), in which case `sel_q` is 0.
- R6: With `REG_OUT=1`, a rising clock edge with `en=1` and `rst=0` loads the tuple computed from the inputs present at that edge, and the outputs show it right after the edge.
- R7: A rising edge with `en=0` and `rst=0` leaves all four output fields unchanged, whatever the inputs do.
- R8: A rising edge with `rst=1` clears all four output fields to zero, and takes priority over `en`.
- R9: Sign bits have no effect on `sel_q`, `min1_q` or `min2_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Cycle-enable strobe for the output register |
| syndrome | input | 1 | Measured syndrome bit of this check |
| msg_in | input | DEG*(MW+1) | Packed sign-magnitude messages, lane i at bits i*(MW+1) +: MW+1 |
| parity_q | output | 1 | Combined sign parity |
| sel_q | output | SW = ceil(log2(DEG)) | Index of the smallest-magnitude lane |
| min1_q | output | MW | Smallest magnitude |
| min2_q | output | MW | Second-smallest magnitude |

## Verification
On every cycle the assertions check the ordering of the tree's result (min1 never above min2), that no lane's magnitude undercuts min1, that the selector stays in range and names a lane whose magnitude equals min1, and that the register loads, holds and clears as R6 to R8 state. The bench's scenarios are the only evidence for the lowest-index tie rule, the exact value of min2, the parity across syndrome values, and sign independence. Each of these depends on comparing a specific input pattern against an independently computed answer.

// File: rtl/cn_pkg.sv
package cn_pkg;
  function automatic int unsigned sel_width(input int unsigned deg);
    int unsigned w;
    w = 1;
    while ((1 << w) < deg) w++;
    return w;
  endfunction
endpackage

// File: rtl/cn_pair_merge.sv
module cn_pair_merge #(
  parameter int MW = 4,
  parameter int SW = 3
) (
  input  logic [MW-1:0] a_m1,
  input  logic [MW-1:0] a_m2,
  input  logic [SW-1:0] a_idx,
  input  logic [MW-1:0] b_m1,
  input  logic [MW-1:0] b_m2,
  input  logic [SW-1:0] b_idx,
  output logic [MW-1:0] o_m1,
  output logic [MW-1:0] o_m2,
  output logic [SW-1:0] o_idx
);
  // Side a always covers lower indices: a wins ties.
  always_comb begin
    if (b_m1 < a_m1) begin
      o_m1  = b_m1;
      o_idx = b_idx;
      o_m2  = (a_m1 < b_m2) ? a_m1 : b_m2;
    end else begin
      o_m1  = a_m1;
      o_idx = a_idx;
      o_m2  = (b_m1 < a_m2) ? b_m1 : a_m2;
    end
  end
endmodule

// File: rtl/cn_min_tree.sv
module cn_min_tree #(
  parameter int DEG = 6,
  parameter int MW  = 4,
  parameter int SW  = 3
) (
  input  logic [DEG*MW-1:0] mags,
  output logic [MW-1:0]     min1,
  output logic [MW-1:0]     min2,
  output logic [SW-1:0]     sel
);
  localparam int LEAVES = 1 << SW;
  localparam int NODES  = 2 * LEAVES - 1;
  localparam logic [MW-1:0] FULL = '1;

  logic [MW-1:0] n_m1  [NODES];
  logic [MW-1:0] n_m2  [NODES];
  logic [SW-1:0] n_idx [NODES];

  generate
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < DEG) begin : g_real
        assign n_m1[LEAVES-1+i] = mags[i*MW +: MW];
      end else begin : g_pad
        assign n_m1[LEAVES-1+i] = FULL;
      end
      assign n_m2[LEAVES-1+i]  = FULL;
      assign n_idx[LEAVES-1+i] = SW'(i);
    end
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
      cn_pair_merge #(.MW(MW), .SW(SW)) u_merge (
        .a_m1 (n_m1[2*k+1]), .a_m2(n_m2[2*k+1]), .a_idx(n_idx[2*k+1]),
        .b_m1 (n_m1[2*k+2]), .b_m2(n_m2[2*k+2]), .b_idx(n_idx[2*k+2]),
        .o_m1 (n_m1[k]),     .o_m2(n_m2[k]),     .o_idx(n_idx[k])
      );
    end
  endgenerate

  assign min1 = n_m1[0];
  assign min2 = n_m2[0];
  assign sel  = n_idx[0];
endmodule

// File: rtl/cn_parity.sv
module cn_parity #(
  parameter int DEG = 6
) (
  input  logic [DEG-1:0] signs,
  input  logic           syndrome,
  output logic           parity
);
  assign parity = (^signs) ^ syndrome;
endmodule

// File: rtl/cn_compress.sv
module cn_compress #(
  parameter int DEG     = 6,
  parameter int MW      = 4,
  parameter bit REG_OUT = 1'b1,
  localparam int SW = cn_pkg::sel_width(DEG),
  localparam int LW = MW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              syndrome,
  input  logic [DEG*LW-1:0] msg_in,
  output logic              parity_q,
  output logic [SW-1:0]     sel_q,
  output logic [MW-1:0]     min1_q,
  output logic [MW-1:0]     min2_q
);
  logic [DEG-1:0]    signs;
  logic [DEG*MW-1:0] mags;
  logic [MW-1:0]     mag_arr [DEG];

  generate
    for (genvar i = 0; i < DEG; i++) begin : g_split
      assign signs[i]            = msg_in[i*LW + MW];
      assign mags[i*MW +: MW]    = msg_in[i*LW +: MW];
      assign mag_arr[i]          = msg_in[i*LW +: MW];
    end
  endgenerate

  logic          c_par;
  logic [SW-1:0] c_sel;
  logic [MW-1:0] c_min1, c_min2;

  cn_parity #(.DEG(DEG)) u_par (
    .signs(signs), .syndrome(syndrome), .parity(c_par)
  );

  cn_min_tree #(.DEG(DEG), .MW(MW), .SW(SW)) u_tree (
    .mags(mags), .min1(c_min1), .min2(c_min2), .sel(c_sel)
  );

  // R4: tree output ordering
  a_r4_min_order: assert property (@(posedge clk) disable iff (rst)
    c_min1 <= c_min2);
  // R5: selector names a real lane
  a_r5_sel_range: assert property (@(posedge clk) disable iff (rst)
    32'(c_sel) < DEG);
  // R3: selected lane carries min1
  a_r3_sel_match: assert property (@(posedge clk) disable iff (rst)
    (32'(c_sel) < DEG) |-> (mag_arr[c_sel] == c_min1));

  generate
    for (genvar i = 0; i < DEG; i++) begin : g_chk
      // R2: no lane undercuts min1
      a_r2_no_smaller: assert property (@(posedge clk) disable iff (rst)
        c_min1 <= mag_arr[i]);
    end

    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          parity_q <= 1'b0;
          sel_q    <= '0;
          min1_q   <= '0;
          min2_q   <= '0;
        end else if (en) begin
          parity_q <= c_par;
          sel_q    <= c_sel;
          min1_q   <= c_min1;
          min2_q   <= c_min2;
        end
      end

      // R6: load on strobe
      a_r6_load: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(rst)) |->
          (parity_q == $past(c_par) && sel_q == $past(c_sel) &&
           min1_q == $past(c_min1) && min2_q == $past(c_min2)));
      // R7: hold without strobe
      a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(en) && !$past(rst)) |->
          ($stable(parity_q) && $stable(sel_q) &&
           $stable(min1_q) && $stable(min2_q)));
      // R8: cleared after reset
      a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!parity_q && sel_q == '0 &&
                        min1_q == '0 && min2_q == '0));
    end else begin : g_comb
      assign parity_q = c_par;
      assign sel_q    = c_sel;
      assign min1_q   = c_min1;
      assign min2_q   = c_min2;
    end
  endgenerate
endmodule

// File: tb/sim_cn_compress.sv
`timescale 1ns/1ps
module sim_cn_compress;
  localparam int DEG = 6;
  localparam int MW  = 4;
  localparam int SW  = 3;
  localparam int LW  = MW + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en  = 1'b0;
  logic              syndrome = 1'b0;
  logic [DEG*LW-1:0] msg_in = '0;
  logic              parity_q;
  logic [SW-1:0]     sel_q;
  logic [MW-1:0]     min1_q, min2_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cn_compress #(.DEG(DEG), .MW(MW), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .en(en), .syndrome(syndrome), .msg_in(msg_in),
    .parity_q(parity_q), .sel_q(sel_q), .min1_q(min1_q), .min2_q(min2_q)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DEG*LW-1:0] pack(input logic [MW:0] l [DEG]);
    logic [DEG*LW-1:0] v;
    for (int i = 0; i < DEG; i++) v[i*LW +: LW] = l[i];
    return v;
  endfunction

  // Drive at falling edge, strobe, sample one ns after rising edge.
  task automatic step(input logic [DEG*LW-1:0] m, input logic s, input logic e);
    @(negedge clk);
    msg_in = m; syndrome = s; en = e;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_tuple(input string tag, input logic [DEG*LW-1:0] m,
                              input logic s);
    int e_m1, e_m2, e_sel, e_par, mg;
    e_m1 = (1 << MW) - 1; e_m2 = e_m1; e_sel = 0; e_par = s;
    for (int i = 0; i < DEG; i++) begin
      mg = int'(m[i*LW +: MW]);
      e_par ^= int'(m[i*LW + MW]);
      if (mg < e_m1) begin e_m2 = e_m1; e_m1 = mg; e_sel = i; end
      else if (mg < e_m2) e_m2 = mg;
    end
    check({tag, " R1"}, "parity", int'(parity_q), e_par);
    check({tag, " R2"}, "min1", int'(min1_q), e_m1);
    check({tag, " R3"}, "sel", int'(sel_q), e_sel);
    check({tag, " R4"}, "min2", int'(min2_q), e_m2);
  endtask

  task automatic t_reset();
    check("R8", "parity at reset", int'(parity_q), 0);
    check("R8", "sel at reset", int'(sel_q), 0);
    check("R8", "min1 at reset", int'(min1_q), 0);
    check("R8", "min2 at reset", int'(min2_q), 0);
  endtask

  task automatic t_distinct();
    logic [MW:0] l [DEG] = '{5'h09, 5'h17, 5'h03, 5'h1C, 5'h05, 5'h0B};
    step(pack(l), 1'b0, 1'b1);
    expect_tuple("distinct", pack(l), 1'b0);
    check("R3", "sel distinct", int'(sel_q), 2);
    check("R4", "min2 distinct", int'(min2_q), 5);
    step(pack(l), 1'b1, 1'b1);
    expect_tuple("distinct syn1", pack(l), 1'b1);
  endtask

  task automatic t_tie();
    logic [MW:0] l [DEG] = '{5'h08, 5'h12, 5'h06, 5'h02, 5'h09, 5'h02};
    step(pack(l), 1'b0, 1'b1);
    check("R3", "sel on tie", int'(sel_q), 1);
    check("R4", "min2 on tie", int'(min2_q), 2);
    check("R2", "min1 on tie", int'(min1_q), 2);
  endtask

  task automatic t_all_full();
    logic [MW:0] l [DEG] = '{5'h0F, 5'h1F, 5'h0F, 5'h0F, 5'h1F, 5'h0F};
    step(pack(l), 1'b1, 1'b1);
    check("R5", "sel all full", int'(sel_q), 0);
    check("R5", "min1 all full", int'(min1_q), 15);
    check("R5", "min2 all full", int'(min2_q), 15);
    check("R1", "parity all full", int'(parity_q), 1);
  endtask

  task automatic t_last_lane();
    logic [MW:0] l [DEG] = '{5'h07, 5'h07, 5'h07, 5'h07, 5'h07, 5'h10};
    step(pack(l), 1'b0, 1'b1);
    check("R3", "sel last lane", int'(sel_q), 5);
    check("R2", "min1 last lane", int'(min1_q), 0);
    check("R4", "min2 last lane", int'(min2_q), 7);
  endtask

  task automatic t_sign_only();
    logic [MW:0] a [DEG] = '{5'h04, 5'h0A, 5'h01, 5'h06, 5'h03, 5'h0C};
    logic [MW:0] b [DEG] = '{5'h14, 5'h1A, 5'h11, 5'h06, 5'h13, 5'h1C};
    logic [SW-1:0] s0; logic [MW-1:0] m10, m20;
    step(pack(a), 1'b0, 1'b1);
    s0 = sel_q; m10 = min1_q; m20 = min2_q;
    step(pack(b), 1'b0, 1'b1);
    check("R9", "sel vs signs", int'(sel_q), int'(s0));
    check("R9", "min1 vs signs", int'(min1_q), int'(m10));
    check("R9", "min2 vs signs", int'(min2_q), int'(m20));
    check("R1", "parity five signs", int'(parity_q), 1);
  endtask

  task automatic t_hold();
    logic [MW:0] a [DEG] = '{5'h05, 5'h0D, 5'h0E, 5'h0B, 5'h02, 5'h09};
    logic [MW:0] b [DEG] = '{5'h11, 5'h00, 5'h1F, 5'h03, 5'h03, 5'h08};
    step(pack(a), 1'b0, 1'b1);
    step(pack(b), 1'b1, 1'b0);
    step(pack(b), 1'b0, 1'b0);
    expect_tuple("hold R7", pack(a), 1'b0);
    step(pack(b), 1'b1, 1'b1);
    expect_tuple("reload R6", pack(b), 1'b1);
  endtask

  task automatic t_reset_priority();
    logic [MW:0] a [DEG] = '{5'h13, 5'h0D, 5'h0E, 5'h0B, 5'h02, 5'h09};
    @(negedge clk);
    rst = 1'b1; en = 1'b1; msg_in = pack(a); syndrome = 1'b1;
    @(posedge clk); #1;
    t_reset();
    @(negedge clk); rst = 1'b0; en = 1'b0;
    @(posedge clk); #1;
    check("R8", "held clear after reset", int'(min2_q), 0);
  endtask

  task automatic t_sweep();
    logic [31:0] lcg = 32'h1234_5678;
    logic [DEG*LW-1:0] m;
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < DEG; i++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        m[i*LW +: LW] = lcg[20 +: LW];
      end
      step(m, lcg[7], 1'b1);
      expect_tuple("sweep R6", m, lcg[7]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_distinct();
    t_tie();
    t_all_full();
    t_last_lane();
    t_sign_only();
    t_hold();
    t_reset_priority();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule